// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block drives an active-low reset line for a small controller system. Two conditions can hold the line low. The first is a supply-valid level from an external comparator. The second is a watchdog: if the host stops producing rising edges on its kick input, the watchdog times out. The block runs from a single system clock, nominally 460.8 kHz, and every interval it uses is a parameter counted in clock cycles.

When the supply has been invalid and then becomes valid again, the reset line stays low for a fixed stretch before it is released. The watchdog watches a window of cycles. If no kick edge arrives inside that window, it produces a reset pulse of fixed width, and then it opens a new window. A configuration bit lets the block supply its own kick from the system clock divided by a power of two, in place of the external pin.

A supply failure always overrides the watchdog. If the supply fails during a watchdog pulse, the pulse is abandoned, and the release then follows the supply stretch alone.

Top module: `rstsup_top`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is low, whatever the other inputs are.
- R2: After `supply_ok` goes low and stays low, `rst_out_n` is low from the 3rd rising clock edge onward (two synchronizer stages plus one output register). It remains low for as long as `supply_ok` stays low.
- R3: After `supply_ok` returns high, `rst_out_n` rises on exactly the (POR_CYC+3)th rising edge. Any dropout of three or more cycles restarts this count, even if the stretch was already under way.
- R4: The kick pin passes through two synchronizer flops and only its rising edges count. A high pulse one clock wide counts as an edge.
- R5: With `int_kick_en` = 0, take a rising edge on `kick_pin` that is not followed by another. `rst_out_n` then falls on the (WIN_CYC+4)th rising clock edge after it. A following rising edge that arrives WIN_CYC cycles after the first or sooner prevents this fall. One that arrives WIN_CYC+1 cycles after the first does not.
- R6: A watchdog reset pulse holds `rst_out_n` low for exactly PULSE_CYC cycles. Kick edges that occur during the pulse have no effect on its length.
- R7: When a watchdog pulse ends, a fresh window opens. If no kick arrives, `rst_out_n` stays high for exactly WIN_CYC cycles and then falls again.
- R8: A supply failure during a watchdog pulse overrides the pulse. The release then comes exactly POR_CYC+3 edges after `supply_ok` returns high, and none of the remaining pulse time carries over.
- R9: With `int_kick_en` = 1, the watchdog takes its kick from a square wave at the clock divided by IKICK_DIV and ignores the pin. When IKICK_DIV is no larger than WIN_CYC, `rst_out_n` never falls while the supply stays valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside the block |
| supply_ok | input | 1 | Comparator result, high when the supply is valid (asynchronous) |
| kick_pin | input | 1 | External watchdog kick from the host (asynchronous) |
| int_kick_en | input | 1 | 1 selects the internal divided-clock kick instead of the pin |
| rst_out_n | output | 1 | Registered active-low reset output |

## Verification
Two events can land on the same clock edge: a kick edge can reach the watchdog in the very cycle its window runs out. The bench provokes this by sweeping the spacing between two single-cycle kick pulses across every value from 2 to WIN_CYC+3. At a spacing of exactly WIN_CYC, the second edge meets the expiry edge head-on. The bench samples the reset line at the (WIN_CYC+4)th edge after the first kick. It expects the line to stay high for spacings up to WIN_CYC and to be low for any larger spacing. A second collision, a supply failure during a watchdog pulse, is judged by the release time, which must follow the supply stretch alone.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  // Watchdog phase: counting the window, or holding the reset pulse.
  typedef enum logic [0:0] {
    WD_WATCH = 1'b0,
    WD_BITE  = 1'b1
  } wd_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/rstsup_kick.sv
module rstsup_kick #(
  parameter int unsigned IKICK_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic int_en,
  output logic kick_edge
);

  localparam int unsigned DIV_W = (IKICK_DIV < 2) ? 1 : $clog2(IKICK_DIV);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic             int_lvl;
  logic             sel_lvl;
  logic             prev_q;

  // Free-running divider; its top bit is a square wave at clk / IKICK_DIV.
  always_comb begin
    div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  generate
    if (IKICK_DIV < 2) begin : g_int_clk
      assign int_lvl = div_q[0];
    end else begin : g_int_div
      assign int_lvl = div_q[DIV_W-1];
    end
  endgenerate

  assign sel_lvl = int_en ? int_lvl : pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel_lvl;
  end

  assign kick_edge = sel_lvl & ~prev_q;

endmodule

// File: rtl/rstsup_por.sv
module rstsup_por #(
  parameter int unsigned POR_CYC = 16128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_s,
  output logic por_hold
);

  localparam int unsigned CNT_W = $clog2(POR_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(POR_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = sup_s && (cnt_q != CNT_END);

  always_comb begin
    cnt_d = cnt_q;
    if (!sup_s)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign por_hold = !sup_s || (cnt_q != CNT_END);

endmodule

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
  import rstsup_pkg::*;
#(
  parameter int unsigned WIN_CYC   = 24422,
  parameter int unsigned PULSE_CYC = 64512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_hold,
  input  logic kick_edge,
  output logic bite
);

  localparam int unsigned CNT_W = $clog2(max_u(WIN_CYC, PULSE_CYC) + 1);
  localparam logic [CNT_W-1:0] WIN_LAST   = CNT_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  wd_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + CNT_W'(1);
    if (por_hold) begin
      st_d  = WD_WATCH;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        WD_WATCH: begin
          if (kick_edge) begin
            cnt_d = '0;
          end else if (cnt_q == WIN_LAST) begin
            st_d  = WD_BITE;
            cnt_d = '0;
          end
        end
        WD_BITE: begin
          if (cnt_q == PULSE_LAST) begin
            st_d  = WD_WATCH;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = WD_WATCH;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WD_WATCH;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign bite = (st_q == WD_BITE);

endmodule

// File: rtl/rstsup_top.sv
module rstsup_top #(
  parameter int unsigned POR_CYC   = 16128,
  parameter int unsigned WIN_CYC   = 24422,
  parameter int unsigned PULSE_CYC = 64512,
  parameter int unsigned IKICK_DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic kick_pin,
  input  logic int_kick_en,
  output logic rst_out_n
);

  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic [1:0] in_s;
  logic       sup_s;
  logic       pin_s;
  logic       kick_edge;
  logic       por_hold;
  logic       wd_bite;
  logic       out_d;
  logic       out_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  rstsup_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({supply_ok, kick_pin}),
    .q     (in_s)
  );
  assign sup_s = in_s[1];
  assign pin_s = in_s[0];

  rstsup_kick #(.IKICK_DIV(IKICK_DIV)) u_kick (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pin_s     (pin_s),
    .int_en    (int_kick_en),
    .kick_edge (kick_edge)
  );

  rstsup_por #(.POR_CYC(POR_CYC)) u_por (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sup_s    (sup_s),
    .por_hold (por_hold)
  );

  rstsup_wdog #(.WIN_CYC(WIN_CYC), .PULSE_CYC(PULSE_CYC)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .por_hold  (por_hold),
    .kick_edge (kick_edge),
    .bite      (wd_bite)
  );

  always_comb begin
    out_d = !(por_hold || wd_bite);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= 1'b0;
    else             out_q <= out_d;
  end

  assign rst_out_n = out_q;

endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk (
  input logic clk,
  input logic arst_n,
  input logic srst_n,
  input logic sup_s,
  input logic por_hold,
  input logic bite,
  input logic kick_edge,
  input logic rst_out_n
);

  // R1
  always @(negedge clk) begin
    if (arst_n === 1'b0) begin
      hw_reset_low_chk: assert (rst_out_n == 1'b0);
    end
  end

  // R2
  sup_low_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !sup_s |=> !rst_out_n);

  // R3
  release_src_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rst_out_n) |-> $past(!por_hold && !bite));

  // R5
  bite_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(bite) |-> $past(!kick_edge && !por_hold));

  // R6
  bite_out_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bite |=> !rst_out_n);

  // R8
  sup_over_bite_chk: assert property (@(posedge clk) disable iff (!srst_n)
    por_hold |=> !bite);

endmodule

bind rstsup_top rstsup_chk u_chk (
  .clk       (clk),
  .arst_n    (rst_n),
  .srst_n    (rst_sync_n),
  .sup_s     (sup_s),
  .por_hold  (por_hold),
  .bite      (wd_bite),
  .kick_edge (kick_edge),
  .rst_out_n (rst_out_n)
);

// File: tb/sim_rstsup_top.sv
`timescale 1ns/1ps
module sim_rstsup_top;

  localparam int POR   = 40;
  localparam int WIN   = 30;
  localparam int PULSE = 50;
  localparam int DIV   = 8;

  logic clk = 1'b0;
  logic rst_n, supply_ok, kick_pin, int_kick_en;
  logic rst_out_n;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  rstsup_top #(.POR_CYC(POR), .WIN_CYC(WIN), .PULSE_CYC(PULSE), .IKICK_DIV(DIV)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .kick_pin    (kick_pin),
    .int_kick_en (int_kick_en),
    .rst_out_n   (rst_out_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until rst_out_n is seen at lvl on a falling edge.
  task automatic edges_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (rst_out_n !== lvl && n < 5000);
  endtask

  task automatic wait_high();
    int g = 0;
    while (rst_out_n !== 1'b1 && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run incomplete actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int lo_cnt;
    int hi_cnt;
    int bad;
    rst_n = 1'b0; supply_ok = 1'b0; kick_pin = 1'b0; int_kick_en = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset holds output low", rst_out_n, 0);

    supply_ok = 1'b0;
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2 low while supply invalid", rst_out_n, 0);

    supply_ok = 1'b1;
    edges_until(1'b1, n);
    chk("R3 stretch after supply valid", n, POR + 3);

    supply_ok = 1'b0;
    edges_until(1'b0, n);
    chk("R2 fall latency", n, 3);
    repeat (5) @(negedge clk);
    chk("R2 stays low", rst_out_n, 0);

    // R3 dropout in the middle of the stretch restarts the count
    supply_ok = 1'b1;
    repeat (10) @(negedge clk);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    edges_until(1'b1, n);
    chk("R3 stretch restart", n, POR + 3);

    // R4 R5: sweep spacing between two single-cycle kick pulses
    for (int s = 2; s <= WIN + 3; s++) begin
      wait_high();
      kick_pin = 1'b1;
      for (int c = 1; c <= WIN + 4; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (c == 1) kick_pin = 1'b0;
        if (c == s) kick_pin = 1'b1;
        if (c == s + 1) kick_pin = 1'b0;
        if (s <= WIN - 2 && c == WIN + 2) kick_pin = 1'b1;
        if (s <= WIN - 2 && c == WIN + 3) kick_pin = 1'b0;
      end
      chk($sformatf("R5 spacing %0d", s), rst_out_n, (s <= WIN) ? 1 : 0);
    end

    // R6: pulse width with kicks during the pulse; R7: next window length
    wait_high();
    kick_pin = 1'b1;
    @(negedge clk);
    kick_pin = 1'b0;
    edges_until(1'b0, n);
    chk("R5 lone kick timeout", n, WIN + 3);
    lo_cnt = 0;
    while (rst_out_n == 1'b0 && lo_cnt < 5000) begin
      lo_cnt++;
      kick_pin = (lo_cnt < PULSE / 2) ? lo_cnt[0] : 1'b0;
      @(negedge clk);
    end
    chk("R6 pulse width", lo_cnt, PULSE);
    hi_cnt = 0;
    while (rst_out_n == 1'b1 && hi_cnt < 5000) begin
      hi_cnt++;
      @(negedge clk);
    end
    chk("R7 window after pulse", hi_cnt, WIN);

    // R8: supply failure late in a watchdog pulse
    repeat (40) @(negedge clk);
    chk("R8 still in pulse", rst_out_n, 0);
    supply_ok = 1'b0;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    edges_until(1'b1, n);
    chk("R8 release follows stretch", n, POR + 3);

    // R9: internal kick source keeps reset released
    int_kick_en = 1'b1;
    bad = 0;
    repeat (6 * (WIN + PULSE)) begin
      @(negedge clk);
      if (rst_out_n !== 1'b1) bad++;
    end
    chk("R9 internal kick no bite", bad, 0);
    int_kick_en = 1'b0;
    edges_until(1'b0, n);
    chk("R9 pin path again times out", (n <= WIN + 6) ? 1 : 0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule